// File: doc/BRIEF.md
# Step Attenuator Control Front End

This block turns the control pins of a 6-bit step attenuator into one registered attenuation code. Each code bit has a fixed weight. From the most significant bit down the weights are 16, 8, 4, 2, 1 and 0.5 dB, so the code value is twice the attenuation in dB and spans 0 to 31.5 dB.

A mode pin selects the source of the next code:
- When the mode pin is low, the source is six parallel pins.
- When the mode pin is high, the source is a 6-bit shift register loaded from a serial data/clock pair.

A latch-enable pin gates the source into the output. While it is high, the output follows the source. While it is low, the output holds.

Power-up is a one-cycle pulse on `pwr_on`. It loads a starting code. That code comes either from the parallel pins or from a four-entry preset table indexed by two preset pins.

The serial data, serial clock and latch enable pass through two-flop synchronizers into the system clock. A rising edge on the synchronized serial clock shifts in one bit.

The output is driven by a three-state machine:
- `ST_IDLE`: after reset, before any power-up pulse. The code stays zero.
- `ST_OPEN`: the latch is transparent and the code follows the source.
- `ST_SHUT`: the latch holds.

The transitions are:
- `T_BOOT`: from any state on `pwr_on`. It goes to `ST_OPEN` when parallel mode and latch enable high are sampled; otherwise it goes to `ST_SHUT`.
- `T_CLOSE`: `ST_OPEN` to `ST_SHUT` when the synchronized latch enable is low.
- `T_REOPEN`: `ST_SHUT` to `ST_OPEN` on a rising edge of the synchronized latch enable.

Top module: `atten_ctrl`

## Requirements
- R1: While `rst_n` is low the code is 0. After reset and before the first `pwr_on` pulse, the code stays 0 whatever the other inputs do.
- R2: Code bit 5 weighs 16 dB, bit 4 8 dB, bit 3 4 dB, bit 2 2 dB, bit 1 1 dB and bit 0 0.5 dB. `par_code[5:0]` carries the same bit positions.
- R3: Each rising edge of `ser_clk` shifts `ser_data` into the shift register. This happens at any latch-enable level. After six edges, the first bit sent sits in bit 5 and the last in bit 0. The shift register resets to zero.
- R4: In serial mode (`mode_serial`=1) with the latch transparent, the code follows the shift register. After a full word has been sent, the code equals that word.
- R5: While the latch holds, changes on `par_code` and serial shifts leave the code unchanged.
- R6: In parallel mode (`mode_serial`=0) with `latch_en` held high, the code follows `par_code` directly.
- R7: In parallel mode with `latch_en` low, a high-then-low pulse on `latch_en` captures `par_code` into the code.
- R8: A `pwr_on` pulse in serial mode loads `par_code` into the code. The latch is then shut until the next rising edge of `latch_en`, even if `latch_en` is already high.
- R9: A `pwr_on` pulse in parallel mode with `latch_en` high loads `par_code`. The code then keeps following the pins.
- R10: A `pwr_on` pulse in parallel mode with `latch_en` low loads a preset selected by {`pwr_sel16`,`pwr_sel8`}:
  - 00 gives code 0;
  - 01 gives 16 (8 dB);
  - 10 gives 32 (16 dB);
  - 11 gives 62 (31 dB, binary 111110).
- R11: `pwr_on` takes priority over any latch update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | Synchronous one-cycle power-up load pulse |
| mode_serial | input | 1 | 1 selects the serial source, 0 selects the parallel pins |
| par_code | input | 6 | Parallel attenuation pins, bit 5 = 16 dB |
| ser_data | input | 1 | Serial data, MSB first |
| ser_clk | input | 1 | Serial shift clock, sampled in the system clock |
| latch_en | input | 1 | 1 = transparent, 0 = hold |
| pwr_sel16 | input | 1 | Preset select, alone gives 16 dB |
| pwr_sel8 | input | 1 | Preset select, alone gives 8 dB |
| atten_code | output | 6 | Registered attenuation code in 0.5 dB units |

## Verification
The bench targets these corner cases, each with the failure it would expose:

- **The both-set preset.** A design that returns all ones there would report 63 instead of 62.
- **The other three preset entries.** A swap of the two select pins would exchange the 8 dB and 16 dB results.
- **Serial bit order.** Random words, shifted while the latch holds and then pulsed in, catch a reversed or truncated register.
- **A serial power-up with latch enable already high.** A design that reopens the latch at once would overwrite the pin value with the stale shift register.
- **The idle window after reset.** Here any follow-through of the pins would show a nonzero code.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_SHUT = 2'd2
    } latch_state_e;

endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdata_s,
    output logic [CODE_W-1:0] shreg
);
    logic sclk_d;
    logic step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
        end
    end

    assign step = sclk_s & ~sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (step) begin
            shreg <= {shreg[CODE_W-2:0], sdata_s};
        end
    end

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (shreg[0] == $past(sdata_s)) && (shreg[CODE_W-1:1] == $past(shreg[CODE_W-2:0])));

    // R3
    shift_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(shreg));
endmodule

// File: rtl/atten_latch_fsm.sv
module atten_latch_fsm
    import atten_ctrl_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              mode_serial,
    input  logic              le_s,
    input  logic [CODE_W-1:0] par_code,
    input  logic [CODE_W-1:0] shreg,
    input  logic              pwr_sel16,
    input  logic              pwr_sel8,
    output logic [CODE_W-1:0] code
);
    localparam logic [CODE_W-1:0] PRE_ZERO = '0;
    localparam logic [CODE_W-1:0] PRE_8DB  = CODE_W'(1) << (CODE_W-2);
    localparam logic [CODE_W-1:0] PRE_16DB = CODE_W'(1) << (CODE_W-1);
    localparam logic [CODE_W-1:0] PRE_TOP  = {{(CODE_W-1){1'b1}}, 1'b0};

    latch_state_e      state, state_nxt;
    logic              le_d;
    logic              le_rise;
    logic [CODE_W-1:0] src;
    logic [CODE_W-1:0] boot_val;
    logic [CODE_W-1:0] code_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            le_d <= 1'b0;
        end else begin
            le_d <= le_s;
        end
    end

    assign le_rise = le_s & ~le_d;
    assign src     = mode_serial ? shreg : par_code;

    always_comb begin
        unique case ({pwr_sel16, pwr_sel8})
            2'b00:   boot_val = PRE_ZERO;
            2'b01:   boot_val = PRE_8DB;
            2'b10:   boot_val = PRE_16DB;
            default: boot_val = PRE_TOP;
        endcase
        if (mode_serial || le_s) begin
            boot_val = par_code;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (pwr_on) begin
            state_nxt = (!mode_serial && le_s) ? ST_OPEN : ST_SHUT;   // T_BOOT
        end else begin
            unique case (state)
                ST_IDLE: state_nxt = ST_IDLE;
                ST_OPEN: if (!le_s)   state_nxt = ST_SHUT;            // T_CLOSE
                ST_SHUT: if (le_rise) state_nxt = ST_OPEN;            // T_REOPEN
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        code_nxt = code;
        if (pwr_on) begin
            code_nxt = boot_val;
        end else begin
            unique case (state)
                ST_IDLE: code_nxt = '0;
                ST_OPEN: code_nxt = src;
                ST_SHUT: code_nxt = code;
                default: code_nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
        end else begin
            code <= code_nxt;
        end
    end

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !pwr_on) |=> (code == '0));

    // R5
    shut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHUT && !pwr_on) |=> $stable(code));

    // R4
    open_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && !pwr_on) |=> (code == $past(src)));

    // R8
    boot_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && mode_serial) |=> (code == $past(par_code)) && (state == ST_SHUT));

    // R10
    boot_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && !mode_serial && !le_s) |=>
            (code == PRE_ZERO || code == PRE_8DB || code == PRE_16DB || code == PRE_TOP));

    // R10
    boot_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && !mode_serial && !le_s && pwr_sel16 && pwr_sel8) |=> (code == PRE_TOP));
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl #(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              mode_serial,
    input  logic [CODE_W-1:0] par_code,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              latch_en,
    input  logic              pwr_sel16,
    input  logic              pwr_sel8,
    output logic [CODE_W-1:0] atten_code
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0]  raw_in;
    logic [NSYNC-1:0]  syn_out;
    logic              sdata_s, sclk_s, le_s;
    logic [CODE_W-1:0] shreg;

    assign raw_in  = {latch_en, ser_clk, ser_data};
    assign sdata_s = syn_out[0];
    assign sclk_s  = syn_out[1];
    assign le_s    = syn_out[2];

    atten_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_out)
    );

    atten_shift #(.CODE_W(CODE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sdata_s (sdata_s),
        .shreg   (shreg)
    );

    atten_latch_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_on      (pwr_on),
        .mode_serial (mode_serial),
        .le_s        (le_s),
        .par_code    (par_code),
        .shreg       (shreg),
        .pwr_sel16   (pwr_sel16),
        .pwr_sel8    (pwr_sel8),
        .code        (atten_code)
    );

    // R11
    boot_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && mode_serial) |=> (atten_code == $past(par_code)));
endmodule

// File: tb/tb_atten_ctrl.sv
module tb_atten_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on = 1'b0;
    logic       mode_serial = 1'b0;
    logic [5:0] par_code = '0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       latch_en = 1'b0;
    logic       pwr_sel16 = 1'b0;
    logic       pwr_sel8 = 1'b0;
    logic [5:0] atten_code;

    int n_checks = 0;
    int n_fail = 0;
    int seed_dummy;
    logic [5:0] expv;
    logic [5:0] w;

    always #10 clk = ~clk;

    atten_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .mode_serial(mode_serial),
        .par_code(par_code), .ser_data(ser_data), .ser_clk(ser_clk),
        .latch_en(latch_en), .pwr_sel16(pwr_sel16), .pwr_sel8(pwr_sel8),
        .atten_code(atten_code)
    );

    function automatic logic [5:0] preset_of(input logic s16, input logic s8);
        if (s16 && s8) return 6'd62;
        if (s16)       return 6'd32;
        if (s8)        return 6'd16;
        return 6'd0;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] exp_v);
        n_checks++;
        if (atten_code !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, atten_code, exp_v);
        end
    endtask

    task automatic do_boot();
        pwr_on = 1'b1;
        cyc(1);
        pwr_on = 1'b0;
        cyc(2);
    endtask

    task automatic pulse_le();
        latch_en = 1'b1;
        cyc(6);
        latch_en = 1'b0;
        cyc(6);
    endtask

    task automatic send_word(input logic [5:0] word);
        for (int i = 5; i >= 0; i--) begin
            ser_data = word[i];
            cyc(4);
            ser_clk = 1'b1;
            cyc(4);
            ser_clk = 1'b0;
            cyc(4);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd4304);
        cyc(3);
        check("R1 reset", 6'd0);
        rst_n = 1'b1;
        latch_en = 1'b1;
        par_code = 6'h2D;
        cyc(8);
        check("R1 idle before boot", 6'd0);

        // R10 presets, parallel mode, latch low
        latch_en = 1'b0;
        cyc(6);
        for (int k = 0; k < 4; k++) begin
            pwr_sel16 = k[1];
            pwr_sel8 = k[0];
            par_code = 6'h15;
            cyc(2);
            do_boot();
            check("R10 preset", preset_of(k[1], k[0]));
            par_code = 6'h0A;
            cyc(4);
            check("R5 hold after preset", preset_of(k[1], k[0]));
        end
        // R2 weights: 31 dB preset is bits 5..1 set
        check("R2 weight 31dB", 6'b111110);

        // R9 boot with latch high in parallel
        latch_en = 1'b1;
        cyc(6);
        par_code = 6'h2B;
        cyc(2);
        do_boot();
        check("R9 boot pins", 6'h2B);
        par_code = 6'h11;
        cyc(3);
        check("R9 follows after boot", 6'h11);

        // R6 direct mode
        for (int k = 0; k < 20; k++) begin
            par_code = 6'($urandom);
            cyc(3);
            check("R6 direct", par_code);
        end

        // R7 latched parallel
        latch_en = 1'b0;
        cyc(6);
        expv = atten_code;
        for (int k = 0; k < 10; k++) begin
            par_code = 6'($urandom);
            cyc(3);
            check("R5 pins ignored", expv);
            pulse_le();
            expv = par_code;
            check("R7 latched", expv);
        end

        // R3 serial shifts with latch low
        mode_serial = 1'b1;
        cyc(3);
        check("R5 mode change while held", expv);
        for (int k = 0; k < 8; k++) begin
            w = (k == 0) ? 6'b100001 : 6'($urandom);
            send_word(w);
            check("R5 shift ignored", expv);
            pulse_le();
            expv = w;
            check("R3 serial word", expv);
        end

        // R4 transparent serial
        latch_en = 1'b1;
        cyc(6);
        w = 6'b011010;
        send_word(w);
        check("R4 transparent", w);
        latch_en = 1'b0;
        cyc(6);
        send_word(6'h0C);
        check("R5 held", w);

        // R8 boot in serial mode with latch high
        latch_en = 1'b1;
        par_code = 6'h33;
        cyc(6);
        do_boot();
        check("R8 serial boot", 6'h33);
        cyc(10);
        check("R11 boot not overwritten", 6'h33);
        latch_en = 1'b0;
        cyc(6);
        latch_en = 1'b1;
        cyc(6);
        check("R8 reopen loads shift reg", 6'h0C);
        latch_en = 1'b0;
        cyc(6);

        // R8 serial boot with latch low ignores presets
        pwr_sel16 = 1'b1;
        pwr_sel8 = 1'b1;
        par_code = 6'h27;
        cyc(2);
        do_boot();
        check("R8 serial boot latch low", 6'h27);

        // R10 random presets
        mode_serial = 1'b0;
        for (int k = 0; k < 12; k++) begin
            pwr_sel16 = 1'($urandom);
            pwr_sel8 = 1'($urandom);
            par_code = 6'($urandom);
            cyc(2);
            do_boot();
            check("R10 random preset", preset_of(pwr_sel16, pwr_sel8));
        end

        // R1 reset again returns to zero
        rst_n = 1'b0;
        cyc(2);
        check("R1 reset mid-run", 6'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule